// File: doc/BRIEF.md
# Timesync Counter with One-Shot Compare Output

The block keeps a 64-bit nanosecond reference counter. While it runs, the counter advances by a fixed step on every clock. Software reaches it through a small synchronous register port with a word index, a write enable, 32-bit write data and registered 32-bit read data.

To set the time, software first halts the counter. It then writes the new value as two words into a load buffer, and a resume command copies the buffer into the counter. The control word also holds a two-bit output routing field. Stop and resume are one-shot command bits that read back as zero, so a read-modify-write of the control word keeps only the routing choice.

A compare unit holds a 63-bit alarm time and an arm bit. Once the counter is at or past the alarm time, the unit fires one time and disarms itself. If the routing field sends compare events to the pin, the output pin toggles.

The counter has two states. CNT_RUN moves to CNT_HALT on the *stop* transition. CNT_HALT moves to CNT_RUN on the *resume-load* transition, which loads the buffer into the counter.

The compare unit also has two states. ALM_IDLE moves to ALM_ARMED on the *arm* transition. ALM_ARMED returns to ALM_IDLE on the *disarm* transition (a high-word write with the arm bit clear) or on the *fire* transition.

Top module: `ts_counter_top`

## Requirements
- R1: An active-low synchronous reset sets the following to zero: the counter, the load buffer, the routing field, the alarm value, the arm bit, the output pin and the read data. After reset the counter is in CNT_RUN.
- R2: The word index selects the register: 0 is control, 1 is counter low, 2 is counter high, 3 is alarm low and 4 is alarm high. Read data is the value the indexed register held at the previous clock edge. Indices 5 to 7 read as zero.
- R3: In CNT_RUN the counter grows by STEP_NS (default 8) at each edge. Indices 1 and 2 read the live counter.
- R4: A control write with bit 1 set halts the counter. The counter holds its value at that edge and afterwards. If bits 1 and 2 are both set, bit 1 takes priority.
- R5: Writes to indices 1 and 2 only fill the load buffer and leave the live counter unchanged. A control write with bit 2 set (and bit 1 clear) in CNT_HALT loads the buffer into the counter at that edge, and counting resumes from the next edge.
- R6: A control bit 2 command issued in CNT_RUN has no effect. The counter keeps counting and the buffer is not loaded.
- R7: Every control write stores bits 17:16 as the routing field. Reading control returns the routing field in bits 17:16 and zeros elsewhere, so bits 1 and 2 always read back as zero.
- R8: The alarm time is the full alarm low word joined with bits 30:0 of the alarm high word. Bit 31 of the high word is the arm bit, and writing the high word with bit 31 clear disarms the unit. Indices 3 and 4 read back the stored value and the live arm bit.
- R9: When the unit is armed and the counter is greater than or equal to the alarm time, the unit fires. The pin toggles at the following edge if routing bit 17 is set.
- R10: Firing clears the arm bit, so the pin toggles only once per arm.
- R11: With routing bit 17 clear, a fire leaves the pin unchanged but still disarms the unit.
- R12: If an alarm high write arrives in the same cycle as a fire, the written arm bit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the indexed register |
| addr | input | ADDR_W | Register word index |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data, one cycle latency |
| sync_out | output | 1 | One-shot compare output pin |

## Verification
The compare unit is tried with three kinds of alarm time:
- An alarm a few dozen steps ahead of a freshly loaded counter shows that the pin toggles once and then stays quiet.
- An alarm already behind the counter shows that the greater-or-equal match fires at once.
- An alarm that is armed and then disarmed before it is reached shows that a disarm really cancels it.

Back-to-back arming writes tell high-word-write priority apart from fire priority. Routing the field off tells event generation apart from pin drive. Stop/load/resume sequences, resume while running and combined stop-plus-resume words tell the counter's two states apart. A long random mix of writes, with alarms placed near the counter, is compared against a cycle model every cycle.

// File: rtl/ts_pkg.sv
package ts_pkg;
    typedef enum logic {CNT_RUN = 1'b0, CNT_HALT = 1'b1} cnt_state_e;
    typedef enum logic {ALM_IDLE = 1'b0, ALM_ARMED = 1'b1} alm_state_e;

    localparam int REG_CTRL   = 0;
    localparam int REG_CNT_LO = 1;
    localparam int REG_CNT_HI = 2;
    localparam int REG_ALM_LO = 3;
    localparam int REG_ALM_HI = 4;

    localparam int BIT_HALT = 1;
    localparam int BIT_GO   = 2;
    localparam int SEL_LSB  = 16;
endpackage

// File: rtl/ts_bus_port.sv
module ts_bus_port
    import ts_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [2*DATA_W-1:0] count,
    input  logic [DATA_W-1:0] alm_lo,
    input  logic [DATA_W-2:0] alm_hi,
    input  logic              armed,
    output logic              halt_cmd,
    output logic              go_cmd,
    output logic              cnt_lo_we,
    output logic              cnt_hi_we,
    output logic              alm_lo_we,
    output logic              alm_hi_we,
    output logic [1:0]        sel,
    output logic [DATA_W-1:0] rdata
);
    logic              ctrl_we;
    logic [1:0]        sel_q;
    logic [DATA_W-1:0] rd_next;

    always_comb begin
        ctrl_we   = wr_en && (addr == ADDR_W'(REG_CTRL));
        cnt_lo_we = wr_en && (addr == ADDR_W'(REG_CNT_LO));
        cnt_hi_we = wr_en && (addr == ADDR_W'(REG_CNT_HI));
        alm_lo_we = wr_en && (addr == ADDR_W'(REG_ALM_LO));
        alm_hi_we = wr_en && (addr == ADDR_W'(REG_ALM_HI));
        halt_cmd  = ctrl_we && wdata[BIT_HALT];
        go_cmd    = ctrl_we && wdata[BIT_GO];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       sel_q <= 2'b00;
        else if (ctrl_we) sel_q <= wdata[SEL_LSB+1:SEL_LSB];
    end
    assign sel = sel_q;

    always_comb begin
        rd_next = '0;
        case (addr)
            ADDR_W'(REG_CTRL):   rd_next[SEL_LSB+1:SEL_LSB] = sel_q;
            ADDR_W'(REG_CNT_LO): rd_next = count[DATA_W-1:0];
            ADDR_W'(REG_CNT_HI): rd_next = count[2*DATA_W-1:DATA_W];
            ADDR_W'(REG_ALM_LO): rd_next = alm_lo;
            ADDR_W'(REG_ALM_HI): rd_next = {armed, alm_hi};
            default:             rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_next;
    end
endmodule

// File: rtl/ts_ref_counter.sv
module ts_ref_counter
    import ts_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int STEP_NS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                halt_cmd,
    input  logic                go_cmd,
    input  logic                lo_we,
    input  logic                hi_we,
    input  logic [DATA_W-1:0]   wdata,
    output logic [2*DATA_W-1:0] count,
    output logic                halted
);
    localparam int CNT_W = 2 * DATA_W;

    cnt_state_e        state_q;
    logic [DATA_W-1:0] buf_lo, buf_hi;
    logic [CNT_W-1:0]  cnt_q;
    logic              resume_load;

    assign resume_load = (state_q == CNT_HALT) && go_cmd && !halt_cmd;

    // state register: stop and resume-load transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CNT_RUN;
        end else begin
            unique case (state_q)
                CNT_RUN:  if (halt_cmd)    state_q <= CNT_HALT;
                CNT_HALT: if (resume_load) state_q <= CNT_RUN;
            endcase
        end
    end

    // load buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_lo <= '0;
            buf_hi <= '0;
        end else begin
            if (lo_we) buf_lo <= wdata;
            if (hi_we) buf_hi <= wdata;
        end
    end

    // counter value
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (resume_load)
            cnt_q <= {buf_hi, buf_lo};
        else if (state_q == CNT_RUN && !halt_cmd)
            cnt_q <= cnt_q + CNT_W'(STEP_NS);
    end

    assign count  = cnt_q;
    assign halted = (state_q == CNT_HALT);
endmodule

// File: rtl/ts_alarm.sv
module ts_alarm
    import ts_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lo_we,
    input  logic                hi_we,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [2*DATA_W-1:0] count,
    input  logic                route,
    output logic [DATA_W-1:0]   cmp_lo,
    output logic [DATA_W-2:0]   cmp_hi,
    output logic                armed,
    output logic                fire,
    output logic                pin
);
    localparam int CNT_W = 2 * DATA_W;

    alm_state_e state_q;
    logic       pin_q;

    assign fire = (state_q == ALM_ARMED) && (count >= {1'b0, cmp_hi, cmp_lo});

    // state register: arm, disarm and fire transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ALM_IDLE;
        end else if (hi_we) begin
            state_q <= wdata[DATA_W-1] ? ALM_ARMED : ALM_IDLE;
        end else begin
            unique case (state_q)
                ALM_IDLE:  state_q <= ALM_IDLE;
                ALM_ARMED: if (fire) state_q <= ALM_IDLE;
            endcase
        end
    end

    // compare value and pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_lo <= '0;
            cmp_hi <= '0;
            pin_q  <= 1'b0;
        end else begin
            if (lo_we) cmp_lo <= wdata;
            if (hi_we) cmp_hi <= wdata[DATA_W-2:0];
            if (fire && route) pin_q <= ~pin_q;
        end
    end

    assign armed = (state_q == ALM_ARMED);
    assign pin   = pin_q;
endmodule

// File: rtl/ts_counter_top.sv
module ts_counter_top
    import ts_pkg::*;
#(
    parameter int STEP_NS = 8,
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              sync_out
);
    localparam int CNT_W = 2 * DATA_W;

    logic              halt_cmd, go_cmd;
    logic              cnt_lo_we, cnt_hi_we, alm_lo_we, alm_hi_we;
    logic [1:0]        sel;
    logic [CNT_W-1:0]  count;
    logic              halted;
    logic [DATA_W-1:0] alm_lo;
    logic [DATA_W-2:0] alm_hi;
    logic              armed, fire;

    ts_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .count(count), .alm_lo(alm_lo), .alm_hi(alm_hi), .armed(armed),
        .halt_cmd(halt_cmd), .go_cmd(go_cmd),
        .cnt_lo_we(cnt_lo_we), .cnt_hi_we(cnt_hi_we),
        .alm_lo_we(alm_lo_we), .alm_hi_we(alm_hi_we),
        .sel(sel), .rdata(rdata)
    );

    ts_ref_counter #(.DATA_W(DATA_W), .STEP_NS(STEP_NS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .halt_cmd(halt_cmd), .go_cmd(go_cmd),
        .lo_we(cnt_lo_we), .hi_we(cnt_hi_we), .wdata(wdata),
        .count(count), .halted(halted)
    );

    ts_alarm #(.DATA_W(DATA_W)) u_alm (
        .clk(clk), .rst_n(rst_n), .lo_we(alm_lo_we), .hi_we(alm_hi_we),
        .wdata(wdata), .count(count), .route(sel[1]),
        .cmp_lo(alm_lo), .cmp_hi(alm_hi), .armed(armed), .fire(fire),
        .pin(sync_out)
    );
endmodule

// File: rtl/ts_counter_chk.sv
module ts_counter_chk #(
    parameter int STEP_NS = 8,
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W-1:0]   wdata,
    input logic [DATA_W-1:0]   rdata,
    input logic [2*DATA_W-1:0] count,
    input logic                halted,
    input logic                armed,
    input logic                fire,
    input logic                route,
    input logic                pin
);
    logic ctrl_w, stop_w, go_w, almhi_w;
    assign ctrl_w  = wr_en && (addr == ADDR_W'(0));
    assign stop_w  = ctrl_w && wdata[1];
    assign go_w    = ctrl_w && wdata[2] && !wdata[1];
    assign almhi_w = wr_en && (addr == ADDR_W'(4));

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (pin == 1'b0 && rdata == '0 && count == '0));

    assert_run_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && !stop_w) |=> (count == $past(count) + (2*DATA_W)'(STEP_NS)));

    assert_halt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !go_w) |=> $stable(count));

    assert_pin_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin) |-> $past(fire && route));

    assert_one_shot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !almhi_w) |=> !armed);

    assert_muted_pin_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !route) |=> $stable(pin));
endmodule

bind ts_counter_top ts_counter_chk #(.STEP_NS(STEP_NS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .count(count), .halted(halted), .armed(armed),
    .fire(fire), .route(sel[1]), .pin(sync_out)
);

// File: tb/sim_ts_counter_top.sv
module sim_ts_counter_top;
    localparam int STEP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sync_out;

    int n_chk = 0;
    int n_bad = 0;
    bit checking = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ts_counter_top #(.STEP_NS(STEP)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sync_out(sync_out)
    );

    // reference model built from the requirements
    logic [63:0] m_cnt;
    logic [31:0] m_blo, m_bhi, m_alo, m_rd;
    logic [30:0] m_ahi;
    logic [1:0]  m_sel;
    logic        m_halt, m_arm, m_pin;

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0:    return {14'b0, m_sel, 16'b0};
            3'd1:    return m_cnt[31:0];
            3'd2:    return m_cnt[63:32];
            3'd3:    return m_alo;
            3'd4:    return {m_arm, m_ahi};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic fire_m, cw;
        if (!rst_n) begin
            m_cnt = '0; m_blo = '0; m_bhi = '0; m_alo = '0; m_ahi = '0;
            m_sel = '0; m_halt = 1'b0; m_arm = 1'b0; m_pin = 1'b0; m_rd = '0;
        end else begin
            fire_m = m_arm && (m_cnt >= {1'b0, m_ahi, m_alo});
            cw = wr_en && addr == 3'd0;
            m_rd = model_read(addr);
            if (fire_m && m_sel[1]) m_pin = ~m_pin;
            if (wr_en && addr == 3'd4) m_arm = wdata[31];
            else if (fire_m)           m_arm = 1'b0;
            if (cw && wdata[1])                m_halt = 1'b1;
            else if (cw && wdata[2] && m_halt) begin m_cnt = {m_bhi, m_blo}; m_halt = 1'b0; end
            else if (!m_halt)                  m_cnt = m_cnt + 64'(STEP);
            if (cw) m_sel = wdata[17:16];
            if (wr_en && addr == 3'd1) m_blo = wdata;
            if (wr_en && addr == 3'd2) m_bhi = wdata;
            if (wr_en && addr == 3'd3) m_alo = wdata;
            if (wr_en && addr == 3'd4) m_ahi = wdata[30:0];
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && checking) begin
            check("R9 pin vs model", {31'b0, sync_out}, {31'b0, m_pin});
            check("R2 read data vs model", rdata, m_rd);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b0; addr = a;
        @(negedge clk);
        v = rdata;
    endtask

    task automatic load_cnt(input logic [31:0] hi, input logic [31:0] lo);
        wr(3'd0, 32'h0000_0002);
        wr(3'd1, lo);
        wr(3'd2, hi);
        wr(3'd0, 32'h0002_0004);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [31:0] v, v2;
        logic        p;
        int          seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 pin after reset", {31'b0, sync_out}, 32'h0);
        check("R1 rdata after reset", rdata, 32'h0);
        checking = 1'b1;
        rd(3'd0, v);  check("R1 routing cleared", v, 32'h0);
        rd(3'd4, v);  check("R1 alarm cleared", v, 32'h0);
        rd(3'd7, v);  check("R2 unmapped index", v, 32'h0);

        // R4 halt holds
        wr(3'd0, 32'h0000_0002);
        rd(3'd1, v); idle(5); rd(3'd1, v2);
        check("R4 halted counter stable", v2, v);
        // R5 buffer write does not touch live value, resume loads it
        wr(3'd1, 32'h1234_5678);
        wr(3'd2, 32'h0000_0001);
        rd(3'd1, v2);
        check("R5 buffer write leaves counter", v2, v);
        wr(3'd0, 32'h0000_0004);
        rd(3'd1, v);  check("R5 loaded low word", v, 32'h1234_5678);
        rd(3'd2, v);  check("R5 loaded high word", v, 32'h0000_0001);
        rd(3'd1, v); rd(3'd1, v2);
        check("R3 counter step between reads", v2 - v, 32'(2 * STEP));

        // R6 resume while running ignored; R7 control readback
        load_cnt(32'h5, 32'h0);
        wr(3'd1, 32'h0); wr(3'd2, 32'h9);
        wr(3'd0, 32'h0002_0004);
        rd(3'd2, v);  check("R6 resume while running ignored", v, 32'h5);
        rd(3'd0, v);  check("R7 control readback", v, 32'h0002_0000);

        // R4 stop and resume together: stop wins
        wr(3'd0, 32'h0002_0006);
        rd(3'd1, v); idle(4); rd(3'd1, v2);
        check("R4 stop wins over resume", v2, v);

        // R9/R10 alarm ahead of the counter
        load_cnt(32'h0, 32'd1000);
        p = sync_out;
        wr(3'd3, 32'd1000 + 32'(STEP * 40));
        wr(3'd4, 32'h8000_0000);
        idle(20);
        check("R9 pin quiet before alarm time", {31'b0, sync_out}, {31'b0, p});
        idle(40);
        check("R9 pin toggled at alarm", {31'b0, sync_out}, {31'b0, ~p});
        idle(30);
        check("R10 no second toggle", {31'b0, sync_out}, {31'b0, ~p});
        rd(3'd4, v);  check("R10 arm bit cleared", v, 32'h0);

        // R9 alarm already passed fires at once
        p = sync_out;
        wr(3'd3, 32'h0); wr(3'd4, 32'h8000_0000); idle(3);
        check("R9 past alarm fires", {31'b0, sync_out}, {31'b0, ~p});

        // R8 disarm before reaching alarm
        load_cnt(32'h0, 32'h0);
        p = sync_out;
        wr(3'd3, 32'(STEP * 30));
        wr(3'd4, 32'h8000_0000);
        wr(3'd4, 32'h0000_0000);
        idle(60);
        check("R8 disarmed alarm silent", {31'b0, sync_out}, {31'b0, p});
        rd(3'd4, v);  check("R8 high word readback", v, 32'h0);
        rd(3'd3, v);  check("R8 low word readback", v, 32'(STEP * 30));

        // R11 routing off
        wr(3'd0, 32'h0000_0000);
        p = sync_out;
        wr(3'd3, 32'h0); wr(3'd4, 32'h8000_0000); idle(3);
        check("R11 muted pin", {31'b0, sync_out}, {31'b0, p});
        rd(3'd4, v);  check("R11 fire still disarms", v, 32'h0);

        // R12 write in the fire cycle wins
        wr(3'd0, 32'h0002_0000);
        p = sync_out;
        wr(3'd4, 32'h8000_0000);
        wr(3'd4, 32'h8000_0000);
        idle(3);
        check("R12 rearm during fire gives two toggles", {31'b0, sync_out}, {31'b0, p});

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int op;
            op = $urandom_range(0, 99);
            if (op < 55) begin
                @(negedge clk); wr_en = 1'b0; addr = 3'($urandom_range(0, 7));
            end else if (op < 65) begin
                wr(3'd0, ($urandom & 32'h0003_0006));
            end else if (op < 75) begin
                wr(3'd1, $urandom);
            end else if (op < 80) begin
                wr(3'd2, 32'($urandom_range(0, 3)));
            end else if (op < 90) begin
                wr(3'd3, m_cnt[31:0] + 32'($urandom_range(0, 40) * STEP));
            end else begin
                wr(3'd4, ($urandom_range(0, 9) == 0) ? 32'h0 : {1'b1, m_cnt[62:32]});
            end
        end
        idle(2);
        checking = 1'b0;
        done = 1'b1;
        summary();
    end
endmodule